// File: doc/BRIEF.md
# PC Card I/O Slave Interface

This block is the target side of a 16-bit PC Card host bus for a peripheral that presents itself as an I/O card. It watches the host chip enables, the register-space select and four strobes. Two of the strobes are I/O read and I/O write. The other two are the memory output-enable and write-enable, which address a card-information table in attribute space. Each qualified cycle is turned into a single request on a simple internal memory port. Host strobes are brought into the internal clock through two-flop synchronizers. WAIT# is held low until the internal side has either delivered read data or latched a write.

A write is posted into a one-entry queue, and the host strobe is released before the internal write takes place. Any later host access sees WAIT# until that queued write has retired. Cycles without the register-space select are dropped, because the card has no common memory. I/O cycles are also refused until an init-complete input and an I/O-mode input are both high. Attribute cycles are served at any time.

Top module: `pcc_io_slave`

## Requirements
- R1: After reset, host_wait_n and host_inpack_n are high, host_rd_oe is low and reg_req is low.
- R2: A strobe seen while host_reg_n is high is ignored. WAIT# stays high, no internal request is made, and the register contents do not change.
- R3: I/O strobes are ignored unless cfg_init_done and cfg_io_mode are both high. No WAIT#, no INPACK#, no data drive and no internal request result. Attribute cycles work regardless of these inputs.
- R4: host_inpack_n goes low only during a qualified I/O read, and never during attribute reads.
- R5: An I/O cycle selects internal word index host_addr[5:1], with reg_attr=0. Address bits [9:6] have no effect.
- R6: An attribute cycle uses host_oe_n/host_we_n, selects word index host_addr[9:1] with reg_attr=1, and carries only the low internal byte. Odd-byte attribute writes are dropped and odd-byte attribute reads return 0x0000.
- R7: Lane rules. Both enables low is a word access (reg_be=11). Only host_ce1_n low with addr[0]=0 is the low byte on data[7:0] (reg_be=01). Only host_ce1_n low with addr[0]=1 is the high internal byte carried on data[7:0] (reg_be=10). Only host_ce2_n low is the high byte on data[15:8] (reg_be=10). Bytes outside the access read as zero.
- R8: host_wait_n goes low on the first clock after a qualified strobe. It returns high while the strobe is still held, once read data is ready or a write is latched.
- R9: A write releases WAIT# before the internal write is performed. A following access keeps WAIT# low until the queued write is acknowledged. Internal requests hold address, data and direction until reg_ack.
- R10: host_rd_oe is high only while a qualified read strobe is active. Otherwise host_rdata is zero.
- R11: Data read back through the host equals the data most recently written to the same location, after lane steering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_init_done | input | 1 | Card initialization finished |
| cfg_io_mode | input | 1 | Card configured for I/O operation |
| host_addr | input | 10 | Host address |
| host_ce1_n | input | 1 | Card enable, low byte (active low) |
| host_ce2_n | input | 1 | Card enable, high byte (active low) |
| host_reg_n | input | 1 | Register/attribute space select (active low) |
| host_iord_n | input | 1 | I/O read strobe (active low) |
| host_iowr_n | input | 1 | I/O write strobe (active low) |
| host_oe_n | input | 1 | Attribute read strobe (active low) |
| host_we_n | input | 1 | Attribute write strobe (active low) |
| host_wdata | input | 16 | Write data from host |
| host_rdata | output | 16 | Read data to host |
| host_rd_oe | output | 1 | Drive enable for the host data pads |
| host_inpack_n | output | 1 | I/O read acknowledge (active low) |
| host_wait_n | output | 1 | Wait request (active low) |
| reg_req | output | 1 | Internal port request |
| reg_we | output | 1 | Internal port write |
| reg_attr | output | 1 | 1 = attribute table, 0 = I/O registers |
| reg_addr | output | 9 | Internal word index |
| reg_be | output | 2 | Internal byte enables |
| reg_wdata | output | 16 | Internal write data |
| reg_rdata | input | 16 | Internal read data, valid with reg_ack |
| reg_ack | input | 1 | Internal request done |

## Verification
The checks assume the host keeps address, enables and write data steady while a strobe is low. They also assume only one strobe is low at a time and that there are at least three idle clocks between strobes. Without that gap, the synchronized view of the previous strobe could overlap the next cycle. The stimulus meets this directly: every host task sets the address and enables together with one strobe, holds them until WAIT# rises, and then idles four clocks. The internal memory model always answers a request with a single-cycle acknowledge after a fixed latency. The latency is raised for the posted-write test, so that the stall on the following access lasts several clocks.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    localparam int HADDR_W  = 10;
    localparam int HDATA_W  = 16;
    localparam int IO_SEL_W = 6;
    localparam int PORT_AW  = HADDR_W - 1;
    localparam int N_STRB   = 4;
    localparam int S_IORD   = 0;
    localparam int S_IOWR   = 1;
    localparam int S_OE     = 2;
    localparam int S_WE     = 3;

    typedef enum logic [1:0] {SP_NONE, SP_IO, SP_ATTR} space_e;

    typedef struct packed {
        logic               valid;
        logic               is_rd;
        space_e             space;
        logic [PORT_AW-1:0] idx;
        logic [1:0]         lane_be;
        logic [1:0]         port_be;
        logic               swap;
    } cyc_t;

    typedef struct packed {
        space_e             space;
        logic [PORT_AW-1:0] idx;
        logic [1:0]         be;
        logic [HDATA_W-1:0] data;
    } wr_entry_t;

    function automatic space_e strobe_space(input logic [N_STRB-1:0] s, input logic io_ok);
        if ((s[S_IORD] || s[S_IOWR]) && io_ok) return SP_IO;
        if (s[S_OE] || s[S_WE])                return SP_ATTR;
        return SP_NONE;
    endfunction

    function automatic logic [1:0] lane_be_f(input logic ce1_n, input logic ce2_n, input logic a0);
        case ({ce2_n, ce1_n})
            2'b00:   return 2'b11;
            2'b10:   return a0 ? 2'b10 : 2'b01;
            2'b01:   return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic lane_swap_f(input logic ce1_n, input logic ce2_n, input logic a0);
        return !ce1_n && ce2_n && a0;
    endfunction

    function automatic logic [HDATA_W-1:0] steer_in(input logic [HDATA_W-1:0] d, input logic swap);
        return swap ? {d[7:0], d[7:0]} : d;
    endfunction

    function automatic logic [HDATA_W-1:0] steer_out(input logic [HDATA_W-1:0] d,
                                                     input logic [1:0] be,
                                                     input logic swap,
                                                     input logic attr);
        logic [HDATA_W-1:0] m;
        m = attr ? {8'h00, d[7:0]} : d;
        case (be)
            2'b11:   return m;
            2'b01:   return {8'h00, m[7:0]};
            2'b10:   return swap ? {8'h00, m[15:8]} : {m[15:8], 8'h00};
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/pcc_strobe_sync.sv
module pcc_strobe_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], async_i[g]};
        end
        assign sync_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/pcc_host_qual.sv
module pcc_host_qual
    import pcc_pkg::*;
(
    input  logic [HADDR_W-1:0] addr,
    input  logic               ce1_n,
    input  logic               ce2_n,
    input  logic               reg_n,
    input  logic [N_STRB-1:0]  strb,
    input  logic               io_ok,
    output logic               valid,
    output logic               is_rd,
    output logic               is_io
);
    space_e sp;
    always_comb begin
        sp    = strobe_space(strb, io_ok);
        valid = !reg_n && (sp != SP_NONE) && (lane_be_f(ce1_n, ce2_n, addr[0]) != 2'b00);
        is_io = (sp == SP_IO);
        is_rd = is_io ? strb[S_IORD] : strb[S_OE];
    end
endmodule

// File: rtl/pcc_cycle_decode.sv
module pcc_cycle_decode
    import pcc_pkg::*;
(
    input  logic [HADDR_W-1:0] addr,
    input  logic               ce1_n,
    input  logic               ce2_n,
    input  logic               reg_n,
    input  logic [N_STRB-1:0]  strb,
    input  logic               io_ok,
    output cyc_t               cyc
);
    localparam int IO_IDX_W = IO_SEL_W - 1;

    always_comb begin
        cyc.space   = strobe_space(strb, io_ok);
        cyc.lane_be = lane_be_f(ce1_n, ce2_n, addr[0]);
        cyc.swap    = lane_swap_f(ce1_n, ce2_n, addr[0]);
        cyc.valid   = !reg_n && (cyc.space != SP_NONE) && (cyc.lane_be != 2'b00);
        if (cyc.space == SP_IO) begin
            cyc.is_rd   = strb[S_IORD];
            cyc.idx     = {{(PORT_AW-IO_IDX_W){1'b0}}, addr[IO_SEL_W-1:1]};
            cyc.port_be = cyc.lane_be;
        end else begin
            cyc.is_rd   = strb[S_OE];
            cyc.idx     = addr[HADDR_W-1:1];
            cyc.port_be = cyc.lane_be & 2'b01;
        end
    end
endmodule

// File: rtl/pcc_post_queue.sv
module pcc_post_queue
    import pcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  wr_entry_t push_entry,
    input  logic      pop,
    output logic      full,
    output wr_entry_t entry
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full  <= 1'b0;
            entry <= '0;
        end else if (push) begin
            full  <= 1'b1;
            entry <= push_entry;
        end else if (pop) begin
            full  <= 1'b0;
        end
    end

    // R9: a new posted write only lands in an empty slot
    p_push_empty_r9: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    // R9: a queued write stays put until it is drained
    p_hold_entry_r9: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> (full && $stable(entry)));
endmodule

// File: rtl/pcc_io_slave.sv
module pcc_io_slave
    import pcc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_init_done,
    input  logic               cfg_io_mode,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic               host_ce1_n,
    input  logic               host_ce2_n,
    input  logic               host_reg_n,
    input  logic               host_iord_n,
    input  logic               host_iowr_n,
    input  logic               host_oe_n,
    input  logic               host_we_n,
    input  logic [HDATA_W-1:0] host_wdata,
    output logic [HDATA_W-1:0] host_rdata,
    output logic               host_rd_oe,
    output logic               host_inpack_n,
    output logic               host_wait_n,
    output logic               reg_req,
    output logic               reg_we,
    output logic               reg_attr,
    output logic [PORT_AW-1:0] reg_addr,
    output logic [1:0]         reg_be,
    output logic [HDATA_W-1:0] reg_wdata,
    input  logic [HDATA_W-1:0] reg_rdata,
    input  logic               reg_ack
);
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_DONE} state_e;

    logic [N_STRB-1:0] raw_strb, s_strb;
    logic              io_ok;
    logic              r_valid, r_is_rd, r_is_io;
    cyc_t              s_cyc;
    state_e            st;
    logic [HDATA_W-1:0] rd_q;
    logic [PORT_AW-1:0] rd_idx;
    space_e             rd_space;
    logic [1:0]         rd_lane_be, rd_port_be;
    logic               rd_swap;
    logic               q_push, q_pop, q_full;
    wr_entry_t          q_in, q_out;

    assign io_ok    = cfg_init_done && cfg_io_mode;
    assign raw_strb = {~host_we_n, ~host_oe_n, ~host_iowr_n, ~host_iord_n};

    pcc_strobe_sync #(.WIDTH(N_STRB), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .async_i(raw_strb), .sync_o(s_strb)
    );

    // asynchronous view of the host cycle drives the pad-side handshakes
    pcc_host_qual raw_qual_i (
        .addr(host_addr), .ce1_n(host_ce1_n), .ce2_n(host_ce2_n), .reg_n(host_reg_n),
        .strb(raw_strb), .io_ok(io_ok),
        .valid(r_valid), .is_rd(r_is_rd), .is_io(r_is_io)
    );

    // synchronized view drives the internal state machine
    pcc_cycle_decode dec_i (
        .addr(host_addr), .ce1_n(host_ce1_n), .ce2_n(host_ce2_n), .reg_n(host_reg_n),
        .strb(s_strb), .io_ok(io_ok), .cyc(s_cyc)
    );

    always_comb begin
        q_in.space = s_cyc.space;
        q_in.idx   = s_cyc.idx;
        q_in.be    = s_cyc.port_be;
        q_in.data  = steer_in(host_wdata, s_cyc.swap);
        q_push     = (st == ST_IDLE) && s_cyc.valid && !s_cyc.is_rd && !q_full
                     && (s_cyc.port_be != 2'b00);
        q_pop      = q_full && reg_ack && (st != ST_READ);
    end

    pcc_post_queue queue_i (
        .clk(clk), .rst(rst), .push(q_push), .push_entry(q_in),
        .pop(q_pop), .full(q_full), .entry(q_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            rd_q       <= '0;
            rd_idx     <= '0;
            rd_space   <= SP_NONE;
            rd_lane_be <= '0;
            rd_port_be <= '0;
            rd_swap    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (s_cyc.valid && !q_full) begin
                        if (s_cyc.is_rd) begin
                            st         <= ST_READ;
                            rd_idx     <= s_cyc.idx;
                            rd_space   <= s_cyc.space;
                            rd_lane_be <= s_cyc.lane_be;
                            rd_port_be <= s_cyc.port_be;
                            rd_swap    <= s_cyc.swap;
                        end else begin
                            st <= ST_DONE;
                        end
                    end
                end
                ST_READ: begin
                    if (reg_ack) begin
                        rd_q <= steer_out(reg_rdata, rd_lane_be, rd_swap, rd_space == SP_ATTR);
                        st   <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (s_strb == '0) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        host_wait_n   = !(r_valid && (st != ST_DONE));
        host_inpack_n = !(r_valid && r_is_rd && r_is_io);
        host_rd_oe    = r_valid && r_is_rd;
        host_rdata    = host_rd_oe ? rd_q : '0;
        reg_req       = (st == ST_READ) || q_full;
        reg_we        = (st != ST_READ);
        if (st == ST_READ) begin
            reg_attr  = (rd_space == SP_ATTR);
            reg_addr  = rd_idx;
            reg_be    = rd_port_be;
            reg_wdata = q_out.data;
        end else begin
            reg_attr  = (q_out.space == SP_ATTR);
            reg_addr  = q_out.idx;
            reg_be    = q_out.be;
            reg_wdata = q_out.data;
        end
    end

    // R9: requests persist, unchanged, until acknowledged
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_ack) |=> reg_req);
    p_req_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_ack) |=> ($stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));
    // R9: a read is only issued once the posted write has drained
    p_read_after_drain_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READ) |-> !q_full);
    // R4: INPACK# only accompanies a driven read
    p_inpack_drive_r4: assert property (@(posedge clk) disable iff (rst)
        !host_inpack_n |-> host_rd_oe);
    // R2: a cycle without the space select never leaves idle
    p_ignore_noreg_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && host_reg_n) |=> (st == ST_IDLE));
    // R3: with I/O gated off and no attribute strobe, nothing starts
    p_init_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !io_ok && !s_strb[S_OE] && !s_strb[S_WE]) |=> (st == ST_IDLE));
endmodule

// File: tb/pcc_io_slave_tb_top.sv
module pcc_io_slave_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_init_done = 1'b0, cfg_io_mode = 1'b1;
    logic [9:0]  host_addr = '0;
    logic        ce1_n = 1'b1, ce2_n = 1'b1, reg_n = 1'b1;
    logic        iord_n = 1'b1, iowr_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rd_oe, host_inpack_n, host_wait_n;
    logic        reg_req, reg_we, reg_attr, reg_ack;
    logic [8:0]  reg_addr;
    logic [1:0]  reg_be;
    logic [15:0] reg_wdata, reg_rdata;

    always #4 clk = ~clk;

    pcc_io_slave dut_i (
        .clk(clk), .rst(rst), .cfg_init_done(cfg_init_done), .cfg_io_mode(cfg_io_mode),
        .host_addr(host_addr), .host_ce1_n(ce1_n), .host_ce2_n(ce2_n), .host_reg_n(reg_n),
        .host_iord_n(iord_n), .host_iowr_n(iowr_n), .host_oe_n(oe_n), .host_we_n(we_n),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rd_oe(host_rd_oe),
        .host_inpack_n(host_inpack_n), .host_wait_n(host_wait_n),
        .reg_req(reg_req), .reg_we(reg_we), .reg_attr(reg_attr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack)
    );

    // internal memory model with adjustable latency
    logic [15:0] io_mem [32];
    logic [15:0] at_mem [512];
    int lat = 1, lat_cnt = 0, wr_count = 0, req_seen = 0;
    always @(posedge clk) begin
        if (rst) begin
            reg_ack   <= 1'b0;
            reg_rdata <= '0;
            lat_cnt   <= 0;
            for (int i = 0; i < 32; i++)  io_mem[i] <= '0;
            for (int i = 0; i < 512; i++) at_mem[i] <= '0;
        end else begin
            reg_ack <= 1'b0;
            if (reg_req) req_seen <= req_seen + 1;
            if (reg_req && !reg_ack) begin
                if (lat_cnt >= lat) begin
                    reg_ack <= 1'b1;
                    lat_cnt <= 0;
                    if (reg_we) begin
                        wr_count <= wr_count + 1;
                        if (reg_attr) begin
                            if (reg_be[0]) at_mem[reg_addr][7:0]  <= reg_wdata[7:0];
                            if (reg_be[1]) at_mem[reg_addr][15:8] <= reg_wdata[15:8];
                        end else begin
                            if (reg_be[0]) io_mem[reg_addr[4:0]][7:0]  <= reg_wdata[7:0];
                            if (reg_be[1]) io_mem[reg_addr[4:0]][15:8] <= reg_wdata[15:8];
                        end
                    end else begin
                        reg_rdata <= reg_attr ? at_mem[reg_addr] : io_mem[reg_addr[4:0]];
                    end
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    int n_chk = 0, n_err = 0, cyc_cnt = 0;
    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt == 100000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    logic [15:0] t_rd;
    logic t_wait_first, t_inpack, t_oe, t_done, t_wait_second;
    int t_cycles, t_req_before, t_wr_at_rel, t_wr_before;

    // kind: 0 I/O write, 1 I/O read, 2 attribute write, 3 attribute read
    task automatic host_cycle(input int kind, input logic [9:0] a, input logic c1, input logic c2,
                              input logic [15:0] wd, input logic regn);
        @(negedge clk);
        host_addr = a; ce1_n = c1; ce2_n = c2; reg_n = regn; host_wdata = wd;
        t_req_before = req_seen; t_wr_before = wr_count;
        case (kind)
            0: iowr_n = 1'b0;
            1: iord_n = 1'b0;
            2: we_n   = 1'b0;
            default: oe_n = 1'b0;
        endcase
        @(negedge clk);
        t_wait_first = !host_wait_n;
        t_inpack = !host_inpack_n;
        @(negedge clk);
        t_wait_second = !host_wait_n;
        t_done = 1'b0; t_cycles = 2;
        for (int i = 0; i < 80; i++) begin
            if (host_wait_n) begin t_done = 1'b1; break; end
            @(negedge clk);
            t_cycles++;
        end
        t_rd = host_rdata; t_oe = host_rd_oe;
        t_inpack = t_inpack | !host_inpack_n;
        t_wr_at_rel = wr_count;
        iord_n = 1'b1; iowr_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        ce1_n = 1'b1; ce2_n = 1'b1; reg_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // {kind, addr, ce1_n, ce2_n, wdata, expected read}
    localparam int NV = 18;
    localparam logic [45:0] VEC [NV] = '{
        {2'd0, 10'h004, 1'b0, 1'b0, 16'hA1B2, 16'h0000},  // R7 word write
        {2'd1, 10'h004, 1'b0, 1'b0, 16'h0000, 16'hA1B2},  // R11 word read
        {2'd0, 10'h006, 1'b0, 1'b1, 16'h0055, 16'h0000},  // R7 even byte, low lane
        {2'd0, 10'h007, 1'b0, 1'b1, 16'h0066, 16'h0000},  // R7 odd byte on low lane
        {2'd1, 10'h006, 1'b0, 1'b0, 16'h0000, 16'h6655},
        {2'd1, 10'h007, 1'b0, 1'b1, 16'h0000, 16'h0066},  // R7 odd byte read on low lane
        {2'd1, 10'h007, 1'b1, 1'b0, 16'h0000, 16'h6600},  // R7 high lane read
        {2'd0, 10'h009, 1'b1, 1'b0, 16'h7700, 16'h0000},  // R7 high lane write
        {2'd1, 10'h008, 1'b0, 1'b0, 16'h0000, 16'h7700},
        {2'd0, 10'h3C4, 1'b0, 1'b0, 16'h1234, 16'h0000},  // R5 upper bits ignored
        {2'd1, 10'h004, 1'b0, 1'b0, 16'h0000, 16'h1234},  // R5
        {2'd2, 10'h010, 1'b0, 1'b1, 16'h00C3, 16'h0000},  // R6 attribute even byte
        {2'd3, 10'h010, 1'b0, 1'b1, 16'h0000, 16'h00C3},
        {2'd2, 10'h3FE, 1'b0, 1'b1, 16'h005A, 16'h0000},  // R6 top index
        {2'd3, 10'h3FE, 1'b0, 1'b1, 16'h0000, 16'h005A},
        {2'd2, 10'h011, 1'b0, 1'b1, 16'h00EE, 16'h0000},  // R6 odd write dropped
        {2'd3, 10'h011, 1'b0, 1'b1, 16'h0000, 16'h0000},  // R6 odd read zero
        {2'd3, 10'h010, 1'b0, 1'b0, 16'h0000, 16'h00C3}   // R6 word read: low byte only
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 wait_n", 32'(host_wait_n), 1);
        chk("R1 inpack_n", 32'(host_inpack_n), 1);
        chk("R1 rd_oe", 32'(host_rd_oe), 0);
        chk("R1 reg_req", 32'(reg_req), 0);

        // R3: I/O refused before init
        host_cycle(0, 10'h002, 1'b0, 1'b0, 16'hBEEF, 1'b0);
        chk("R3 no wait on gated write", 32'(t_wait_first), 0);
        chk("R3 no request on gated write", 32'(req_seen - t_req_before), 0);
        host_cycle(1, 10'h002, 1'b0, 1'b0, 16'h0000, 1'b0);
        chk("R3 no inpack before init", 32'(t_inpack), 0);
        chk("R10 no drive on gated read", 32'(t_oe), 0);
        host_cycle(2, 10'h020, 1'b0, 1'b1, 16'h0011, 1'b0);
        host_cycle(3, 10'h020, 1'b0, 1'b1, 16'h0000, 1'b0);
        chk("R3 attribute works before init", 32'(t_rd), 32'h0011);

        cfg_init_done = 1'b1;
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  k;
            logic [15:0] exp;
            k   = VEC[v][45:44];
            exp = VEC[v][15:0];
            host_cycle(int'(k), VEC[v][43:34], VEC[v][33], VEC[v][32], VEC[v][31:16], 1'b0);
            chk("R8 wait asserted", 32'(t_wait_first), 1);
            chk("R8 wait released", 32'(t_done), 1);
            if (k == 2'd1) begin
                chk("R7 read data", 32'(t_rd), 32'(exp));
                chk("R4 inpack on I/O read", 32'(t_inpack), 1);
                chk("R10 drive on read", 32'(t_oe), 1);
            end else if (k == 2'd3) begin
                chk("R6 attribute read data", 32'(t_rd), 32'(exp));
                chk("R4 no inpack on attribute read", 32'(t_inpack), 0);
            end
        end

        // R2: no space select
        host_cycle(0, 10'h004, 1'b0, 1'b0, 16'hDEAD, 1'b1);
        chk("R2 no wait", 32'(t_wait_first), 0);
        chk("R2 no request", 32'(req_seen - t_req_before), 0);
        host_cycle(1, 10'h004, 1'b0, 1'b0, 16'h0000, 1'b0);
        chk("R2 register unchanged", 32'(t_rd), 32'h1234);

        // R3: I/O mode off
        cfg_io_mode = 1'b0;
        host_cycle(1, 10'h004, 1'b0, 1'b0, 16'h0000, 1'b0);
        chk("R3 no inpack without io mode", 32'(t_inpack), 0);
        chk("R3 no wait without io mode", 32'(t_wait_first), 0);
        cfg_io_mode = 1'b1;

        // R10: idle bus not driven
        chk("R10 idle no drive", 32'(host_rd_oe), 0);
        chk("R10 idle data zero", 32'(host_rdata), 0);

        // R9: posted write then stalled read
        lat = 10;
        host_cycle(0, 10'h00A, 1'b0, 1'b0, 16'h5A5A, 1'b0);
        chk("R9 wait released before internal write", 32'(t_wr_at_rel - t_wr_before), 0);
        host_cycle(1, 10'h00A, 1'b0, 1'b0, 16'h0000, 1'b0);
        chk("R9 read stalled by queued write", 32'(t_wait_second), 1);
        chk("R9 stall length", 32'(t_cycles > 8), 1);
        chk("R11 read after posted write", 32'(t_rd), 32'h5A5A);
        lat = 1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule